// File: doc/BRIEF.md
# Half-Duplex Multi-Lane SPI Master

This block drives a serial peripheral over shared, bidirectional data lines, one direction at a time. A transaction has a write phase, in which the master drives the lines, followed by an optional read phase, in which it lets go of the lines and samples what the peripheral drives. The lane mode is chosen per transaction. In single mode, one bidirectional line (IO0) carries both directions, as on a three-wire bus. Dual mode uses IO0 and IO1. Quad mode uses IO0 to IO3.

The host pulses `start` with a lane mode, a write byte count and a read byte count. It supplies write bytes on `tx_data`. The master accepts each byte in the cycle where `tx_take` is high. Read bytes come back on `rx_data`, each marked by a one-cycle `rx_valid`. Chip select, the serial clock and the per-line output enables are driven by the block. The pad layer combines `io_out` and `io_oe` into tri-state buffers and returns the pin levels on `io_in`. Command and address sequencing for particular memory devices sits above this block.

Top module: `hd_spi_master`

## Requirements
- R1: Lane mode code 0 selects one line (IO0), code 1 selects two lines (IO0–IO1), and codes 2 and 3 select four lines (IO0–IO3). During the write phase `io_oe` is 4'b0001, 4'b0011 or 4'b1111 respectively.
- R2: Bytes go out most significant bit first. Each SCLK cycle carries 1, 2 or 4 bits, and the highest bit of each group sits on the highest-numbered line in use.
- R3: SCLK idles low and follows mode 0 timing. Output data changes only while SCLK is low, and the master samples `io_in` at each rising SCLK edge of the read phase.
- R4: The write phase sends exactly `wr_count` bytes. Each byte takes 8, 4 or 2 SCLK cycles for one, two or four lanes, and each byte is taken from `tx_data` in a cycle where `tx_take` is high.
- R5: Before the read phase there is exactly one SCLK cycle during which all four output enables are low and nothing is sampled. A read of N bytes therefore shows N×(8/lanes)+1 rising SCLK edges with `io_oe` at zero.
- R6: The read phase assembles `rd_count` bytes, most significant group first, from the lines named in R1. Each byte is presented on `rx_data` with a one-cycle `rx_valid` pulse.
- R7: `cs_n` goes low when `start` is accepted and stays low without a break through both phases. It rises only at the falling SCLK edge that ends the last bit.
- R8: A read count of zero ends the transaction after the last write bit, with no turnaround cycle.
- R9: While `cs_n` is high, `io_oe` is 4'b0000 and SCLK is low, including directly after reset.
- R10: A write count of zero with a nonzero read count starts straight with the turnaround cycle. A `start` with both counts zero is ignored, and `cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled only while idle) |
| lane_mode | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| wr_count | input | CNT_W | Number of bytes to write |
| rd_count | input | CNT_W | Number of bytes to read |
| tx_data | input | 8 | Next write byte |
| tx_take | output | 1 | `tx_data` is consumed at this clock edge |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Values driven onto the data lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Levels seen on the data lines |

## Verification
The bench runs every lane mode with every write count and every read count from zero to three, and checks each SCLK group against its own shift arithmetic. Distinct byte patterns per byte expose swapped lines, reversed bit order and a missed reload. The counts of zero in each phase separate a skipped turnaround from a missing one. The slave model indexes its read data from the first rising edge after the turnaround, so an extra or missing turnaround cycle shows up as a shifted read byte as well as a wrong edge count.

// File: rtl/hd_spi_pkg.sv
package hd_spi_pkg;

  localparam int BYTE_W = 8;
  localparam int LANE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_TURN  = 2'd2,
    ST_READ  = 2'd3
  } spi_state_e;

  // lines enabled for a lane-mode code
  function automatic logic [LANE_W-1:0] lane_mask(input logic [1:0] m);
    case (m)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // SCLK cycles per byte
  function automatic logic [3:0] beats_of(input logic [1:0] m);
    case (m)
      2'd0:    beats_of = 4'd8;
      2'd1:    beats_of = 4'd4;
      default: beats_of = 4'd2;
    endcase
  endfunction

  // top bits of the shift register placed on the low lines, msb on highest line
  function automatic logic [LANE_W-1:0] out_group(input logic [BYTE_W-1:0] sh,
                                                  input logic [1:0] m);
    case (m)
      2'd0:    out_group = {3'b000, sh[7]};
      2'd1:    out_group = {2'b00, sh[7:6]};
      default: out_group = sh[7:4];
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] shift_out(input logic [BYTE_W-1:0] sh,
                                                  input logic [1:0] m);
    case (m)
      2'd0:    shift_out = {sh[6:0], 1'b0};
      2'd1:    shift_out = {sh[5:0], 2'b00};
      default: shift_out = {sh[3:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] merge_in(input logic [BYTE_W-1:0] sh,
                                                 input logic [LANE_W-1:0] io,
                                                 input logic [1:0] m);
    case (m)
      2'd0:    merge_in = {sh[6:0], io[0]};
      2'd1:    merge_in = {sh[5:0], io[1:0]};
      default: merge_in = {sh[3:0], io[3:0]};
    endcase
  endfunction

endpackage

// File: rtl/hd_spi_sclk_gen.sv
module hd_spi_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          sclk_q;
  logic          tick;

  assign tick    = run && (cnt == '0);
  assign rise_ev = tick && !sclk_q;
  assign fall_ev = tick && sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= RELOAD;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt    <= RELOAD;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt    <= RELOAD;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hd_spi_shifter.sv
module hd_spi_shifter
  import hd_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift_tx,
  input  logic              samp,
  input  logic [LANE_W-1:0] io_in,
  output logic [LANE_W-1:0] tx_group,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;

  assign tx_group = out_group(tx_sh, mode);
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load)          tx_sh <= load_byte;
      else if (shift_tx) tx_sh <= shift_out(tx_sh, mode);
      if (samp)          rx_sh <= merge_in(rx_sh, io_in, mode);
    end
  end
endmodule

// File: rtl/hd_spi_master.sv
module hd_spi_master
  import hd_spi_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        lane_mode,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [CNT_W-1:0]  rd_count,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_take,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              cs_n,
  output logic              sclk,
  output logic [LANE_W-1:0] io_out,
  output logic [LANE_W-1:0] io_oe,
  input  logic [LANE_W-1:0] io_in
);
  spi_state_e        st;
  logic [1:0]        mode_q;
  logic [CNT_W-1:0]  wr_left;
  logic [CNT_W-1:0]  rd_left;
  logic [3:0]        beat_left;
  logic [BYTE_W-1:0] rx_data_q;
  logic              rx_valid_q;

  // named internal events
  logic accept, rise_ev, fall_ev, samp_ev, turn_phase;
  logic wr_byte_end, rd_byte_end, reload, shift_tx;
  logic [LANE_W-1:0] tx_group;
  logic [BYTE_W-1:0] rx_byte;

  assign accept      = (st == ST_IDLE) && start && ((wr_count != '0) || (rd_count != '0));
  assign wr_byte_end = (st == ST_WRITE) && fall_ev && (beat_left == 4'd1);
  assign rd_byte_end = (st == ST_READ) && fall_ev && (beat_left == 4'd1);
  assign reload      = wr_byte_end && (wr_left > CNT_W'(1));
  assign shift_tx    = (st == ST_WRITE) && fall_ev && (beat_left > 4'd1);
  assign samp_ev     = (st == ST_READ) && rise_ev;
  assign turn_phase  = (st == ST_TURN);
  assign tx_take     = (accept && (wr_count != '0)) || reload;

  hd_spi_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st != ST_IDLE),
    .sclk    (sclk),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  hd_spi_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .load      (tx_take),
    .load_byte (tx_data),
    .shift_tx  (shift_tx),
    .samp      (samp_ev),
    .io_in     (io_in),
    .tx_group  (tx_group),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      mode_q     <= 2'd0;
      wr_left    <= '0;
      rd_left    <= '0;
      beat_left  <= 4'd0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= rd_byte_end;
      if (rd_byte_end) rx_data_q <= rx_byte;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            mode_q    <= lane_mode;
            wr_left   <= wr_count;
            rd_left   <= rd_count;
            beat_left <= beats_of(lane_mode);
            st        <= (wr_count != '0) ? ST_WRITE : ST_TURN;
          end
        end
        ST_WRITE: begin
          if (shift_tx) begin
            beat_left <= beat_left - 4'd1;
          end else if (wr_byte_end) begin
            if (reload) begin
              wr_left   <= wr_left - 1'b1;
              beat_left <= beats_of(mode_q);
            end else if (rd_left != '0) begin
              st <= ST_TURN;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_TURN: begin
          if (fall_ev) begin
            st        <= ST_READ;
            beat_left <= beats_of(mode_q);
          end
        end
        ST_READ: begin
          if (fall_ev) begin
            if (beat_left > 4'd1) begin
              beat_left <= beat_left - 4'd1;
            end else begin
              rd_left <= rd_left - 1'b1;
              if (rd_left == CNT_W'(1)) st <= ST_IDLE;
              else beat_left <= beats_of(mode_q);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cs_n     = (st == ST_IDLE);
  assign io_oe    = (st == ST_WRITE) ? lane_mask(mode_q) : '0;
  assign io_out   = (st == ST_WRITE) ? tx_group : '0;
  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
endmodule

// File: rtl/hd_spi_master_chk.sv
module hd_spi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       rx_valid,
  input logic       fall_ev,
  input logic       samp_ev,
  input logic       turn_phase
);
  assert_oe_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  assert_sclk_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_lane_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'b0000) |-> (io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));

  assert_turn_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    turn_phase |-> (io_oe == 4'b0000));

  assert_sample_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ev |-> (io_oe == 4'b0000) && !cs_n);

  assert_cs_release_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(fall_ev));

  assert_rx_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall_ev));
endmodule

bind hd_spi_master hd_spi_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .io_oe      (io_oe),
  .rx_valid   (rx_valid),
  .fall_ev    (fall_ev),
  .samp_ev    (samp_ev),
  .turn_phase (turn_phase)
);

// File: tb/hd_spi_master_bench.sv
module hd_spi_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] lane_mode = 2'd0;
  logic [CNT_W-1:0] wr_count = '0;
  logic [CNT_W-1:0] rd_count = '0;
  logic [7:0] tx_data;
  logic       tx_take;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       cs_n, sclk;
  logic [3:0] io_out, io_oe, io_in;

  int tests = 0, fails = 0;
  int tx_idx = 0;
  int tbase = 0, salt = 0, cur_lanes = 1;
  int wcnt = 0, wbad = 0, oebad = 0, nrise = 0, rxcnt = 0, rxbad = 0;
  int cs_rises = 0, idle_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] tx_pat(input int k);
    return 8'((k * 59 + 150) & 255);
  endfunction
  function automatic logic [7:0] rx_pat(input int k);
    return 8'(((k * 87) ^ 195) & 255);
  endfunction
  function automatic logic [3:0] grp(input logic [7:0] b, input int lanes, input int beat);
    int v;
    v = (int'(b) >> (8 - lanes * (beat + 1))) & ((1 << lanes) - 1);
    return 4'(v);
  endfunction
  function automatic logic [3:0] slave_io(input int rises, input int lanes, input int s);
    int bpb, idx;
    if (rises == 0) return 4'b0000;
    bpb = 8 / lanes;
    idx = rises - 1;
    return grp(rx_pat(s + idx / bpb), lanes, idx % bpb);
  endfunction

  assign tx_data = tx_pat(tx_idx);
  assign io_in   = slave_io(nrise, cur_lanes, salt);

  always @(posedge clk) if (tx_take) tx_idx <= tx_idx + 1;

  hd_spi_master #(.CNT_W(CNT_W), .HALF_DIV(2)) u_hd_spi_master (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_mode(lane_mode),
    .wr_count(wr_count), .rd_count(rd_count), .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .cs_n(cs_n), .sclk(sclk),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  // bus monitor, sampled between clock edges
  always @(negedge clk) begin
    int bpb;
    logic [3:0] msk, ex;
    bpb = 8 / cur_lanes;
    msk = 4'((1 << cur_lanes) - 1);
    if (prev_cs && !cs_n) begin
      wcnt = 0; wbad = 0; oebad = 0; nrise = 0; rxcnt = 0; rxbad = 0;
    end
    if (rst_n && cs_n && (io_oe != 4'b0 || sclk)) idle_bad++;
    if (!cs_n && sclk && !prev_sclk) begin
      if (io_oe != 4'b0) begin
        ex = grp(tx_pat(tbase + wcnt / bpb), cur_lanes, wcnt % bpb);
        if ((io_out & msk) != ex) wbad++;
        if (io_oe != msk) oebad++;
        wcnt++;
      end else begin
        nrise++;
      end
    end
    if (rx_valid) begin
      if (rx_data != rx_pat(salt + rxcnt)) rxbad++;
      rxcnt++;
    end
    if (!prev_cs && cs_n) cs_rises++;
    prev_cs   = cs_n;
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int m, input int wr, input int rd);
    int lanes, bpb, cs0, guard, exp_r;
    lanes = (m == 0) ? 1 : (m == 1) ? 2 : 4;
    bpb = 8 / lanes;
    @(negedge clk);
    cur_lanes = lanes;
    salt = salt + 7;
    tbase = tx_idx;
    cs0 = cs_rises;
    lane_mode = 2'(m);
    wr_count = CNT_W'(wr);
    rd_count = CNT_W'(rd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!cs_n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(wcnt == wr * bpb, "R4 write beats", wcnt, wr * bpb);
    check(wbad == 0, "R2 write groups", wbad, 0);
    check(oebad == 0, "R1 enable mask", oebad, 0);
    exp_r = (rd > 0) ? rd * bpb + 1 : 0;
    check(nrise == exp_r, (rd == 0) ? "R8 no turnaround" :
          (wr == 0) ? "R10 turnaround only" : "R5 turnaround edges", nrise, exp_r);
    check(rxcnt == rd, "R6 read bytes", rxcnt, rd);
    check(rxbad == 0, "R3 read sampling", rxbad, 0);
    check(cs_rises - cs0 == 1, "R7 single select", cs_rises - cs0, 1);
    check(tx_idx - tbase == wr, "R4 tx_take count", tx_idx - tbase, wr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R9 reset cs_n", int'(cs_n), 1);
    check(sclk == 1'b0, "R9 reset sclk", int'(sclk), 0);
    check(io_oe == 4'b0, "R9 reset oe", int'(io_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // both counts zero: start ignored
    begin
      int c0;
      c0 = cs_rises;
      lane_mode = 2'd2; wr_count = '0; rd_count = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) begin
        @(negedge clk);
        check(cs_n == 1'b1, "R10 zero counts ignored", int'(cs_n), 1);
      end
      check(cs_rises == c0, "R10 no select", cs_rises - c0, 0);
    end

    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
        for (int r = 0; r < 4; r++)
          if (w + r > 0) run_xfer(m, w, r);

    check(idle_bad == 0, "R9 idle lines", idle_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule